// File: doc/BRIEF.md
# Status Register and Array Write Guard for a Serial Memory

This block holds the eight-bit status word of a 256-byte serial memory and decides whether an array write may go ahead. It keeps a write-enable flag, a busy flag for the self-timed programming cycle, and a two-bit protection code that survives an ordinary reset. A serial front-end decodes opcodes and bit counts. It hands the block single-cycle strobes: enable writes, disable writes, "status data byte fully shifted in", one strobe per serial clock rising edge, and one per chip-select rising edge. In return the front-end reads back the status word and a grant for the address it wants to program.

A status write is held back until chip select rises directly after the last data bit. If one more serial clock comes first, the write is dropped. Once a programming cycle starts, the busy flag stays high for a fixed number of system clocks. A new protection code takes effect only when that delay ends, so until then reads show the old code. A low level on the write-protect pin clears the write-enable flag at any time, but it cannot stop a cycle that is already running.

Top module: `sr_status_guard`

## Requirements
- R1: `status_o` is `{4'b1111, bp[1], bp[0], wel, wip}`: bits 7..4 always read 1, bits 3..2 hold the protection code, bit 1 the write-enable flag, bit 0 the busy flag. It is valid in every cycle, including during a programming cycle.
- R2: A `wren_i` strobe sets the write-enable flag, and a `wrdi_i` strobe clears it. Either change shows in the cycle after the strobe. A synchronous reset (`rst_n` low) clears the flag and any running cycle.
- R3: While `wp_n_i` is low, the write-enable flag is cleared in the next cycle and `wren_i` has no effect. A status write latched while `wp_n_i` is low is not armed.
- R4: The protected address range depends on the code `{bp1,bp0}`: 00 protects nothing, 01 protects 0xC0–0xFF, 10 protects 0x80–0xFF, and 11 protects 0x00–0xFF.
- R5: `wr_grant_o` is 1 for `addr_i` only when the write-enable flag is 1, `wp_n_i` is high, no cycle is running, and the address is outside the protected range.
- R6: An `arr_commit_i` strobe with `wr_grant_o` high starts a programming cycle. Busy reads 1 for WR_CYCLES cycles starting the cycle after the strobe. A commit without a grant is ignored.
- R7: The write-enable flag clears in the same cycle that busy falls at the end of any programming cycle.
- R8: `wrsr_latch_i` arms a status write only when the write-enable flag is 1, `wp_n_i` is high and no cycle is running. An armed write starts a cycle on the next `cs_rise_i`, unless a `sclk_rise_i` comes first (or in the same cycle), in which case the write is dropped.
- R9: During a status-write cycle the old protection code reads back. The new code appears in the same cycle that busy falls.
- R10: The protection code is not touched by `rst_n`. Only `bp_init_i` clears it to 00, and it leaves the write-enable flag alone.
- R11: Taking `wp_n_i` low during a running cycle clears the write-enable flag but does not shorten the cycle or cancel its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (volatile state only) |
| bp_init_i | input | 1 | Initial-state strobe: protection code to 00 |
| wp_n_i | input | 1 | Hardware write-protect, low = protect |
| wren_i | input | 1 | Enable-writes command strobe |
| wrdi_i | input | 1 | Disable-writes command strobe |
| wrsr_latch_i | input | 1 | Status data byte fully shifted in |
| wrsr_bp_i | input | 2 | Protection code carried by that byte |
| sclk_rise_i | input | 1 | Serial clock rising edge while selected |
| cs_rise_i | input | 1 | Chip-select rising edge (deselect) |
| arr_commit_i | input | 1 | Request to start an array programming cycle |
| addr_i | input | 8 | Byte address to be programmed |
| wr_grant_o | output | 1 | Array write allowed for addr_i |
| status_o | output | 8 | Status word read-back |

## Verification
Every status bit is a register, so the effect of a strobe is due in the cycle right after the edge that samples it. The grant is combinational on the address and the current flags, so it is due in the same cycle the address is driven. A programming cycle started at edge E shows busy from E through edge E+WR_CYCLES−1. The cleared write-enable flag and any new protection code are due after edge E+WR_CYCLES. The driver stamps each expected item with the cycle index when it is due. The monitor compares only in that cycle, at the falling clock edge, and flags any item left past its due cycle.

// File: rtl/sr_pkg.sv
// Package: shared constants and types for the status/protection block.
// Assumes a two-bit protection code and an eight-bit status word.
package sr_pkg;
    localparam int BP_W     = 2;
    localparam int STATUS_W = 8;
    localparam logic [3:0] STATUS_FILL = 4'b1111;

    typedef enum logic {
        CYC_ARRAY  = 1'b0,
        CYC_STATUS = 1'b1
    } cyc_kind_e;
endpackage

// File: rtl/sr_wel_latch.sv
// Module: write-enable flag.
// Set by an enable strobe, cleared by a disable strobe, by a low write-protect
// level, at the end of any programming cycle and by reset.
// Assumes all inputs are synchronous single-cycle strobes or levels.
module sr_wel_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic wp_n_i,
    input  logic wren_i,
    input  logic wrdi_i,
    input  logic cycle_done_i,
    output logic wel_o
);
    logic wel_q;

    // Clear conditions take priority over the set strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_q <= 1'b0;
        end else if (!wp_n_i || wrdi_i || cycle_done_i) begin
            wel_q <= 1'b0;
        end else if (wren_i) begin
            wel_q <= 1'b1;
        end
    end

    assign wel_o = wel_q;

    // R3: a low protect level leaves the flag cleared on the next cycle.
    p_wp_clears_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n_i |=> !wel_o)
        else $error("p_wp_clears_wel_r3");
endmodule

// File: rtl/sr_wrsr_gate.sv
// Module: status-write arming gate.
// Arms when the status data byte is latched with permission, and fires a
// start pulse on the next deselect only if no extra serial clock came first.
// Assumes the latch strobe's own serial clock is not also sent as sclk_rise_i.
module sr_wrsr_gate
    import sr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            allow_i,
    input  logic            latch_i,
    input  logic [BP_W-1:0] data_i,
    input  logic            sclk_rise_i,
    input  logic            cs_rise_i,
    output logic            start_o,
    output logic [BP_W-1:0] pend_bp_o
);
    logic            armed_q;
    logic [BP_W-1:0] pend_q;

    // Start only on a clean deselect directly after the last data bit.
    assign start_o   = armed_q && cs_rise_i && !sclk_rise_i;
    assign pend_bp_o = pend_q;

    // Arm on a permitted latch; disarm on an extra clock or any deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (latch_i) begin
            armed_q <= allow_i;
        end else if (sclk_rise_i || cs_rise_i) begin
            armed_q <= 1'b0;
        end
    end

    // Capture the requested protection code with the latch strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (latch_i) begin
            pend_q <= data_i;
        end
    end

    // R8: an extra serial clock after arming drops the pending write.
    p_extra_clock_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && sclk_rise_i && !latch_i) |=> !start_o)
        else $error("p_extra_clock_drops_r8");
endmodule

// File: rtl/sr_write_timer.sv
// Module: self-timed programming cycle.
// Holds busy for WR_CYCLES cycles after a start pulse and flags the final
// cycle so that the caller can commit results and clear write enable.
// Assumes start is never issued while busy (callers gate on busy).
module sr_write_timer
    import sr_pkg::*;
#(
    parameter int WR_CYCLES = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  cyc_kind_e kind_i,
    output logic      busy_o,
    output logic      done_o,
    output cyc_kind_e kind_o
);
    localparam int CNT_W = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WR_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    cyc_kind_e        kind_q;

    assign busy_o = busy_q;
    assign done_o = busy_q && (cnt_q == '0);
    assign kind_o = kind_q;

    // Load the down-counter on start, count to zero, then drop busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            kind_q <= CYC_ARRAY;
        end else if (start_i && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_LAST;
            kind_q <= kind_i;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R6: callers never request a new cycle while one is running.
    p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o)
        else $error("p_no_restart_r6");

    // R6: counter never exceeds the programmed length.
    p_cnt_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (cnt_q <= CNT_LAST))
        else $error("p_cnt_in_range_r6");
endmodule

// File: rtl/sr_block_protect.sv
// Module: protected-range decoder.
// Maps the two-bit protection code to an address range at the top of the
// array: none, upper quarter, upper half or everything.
// Assumes ADDR_W >= 2.
module sr_block_protect
    import sr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [BP_W-1:0]   bp_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    localparam int MSB = ADDR_W - 1;

    logic upper_half;
    logic upper_quarter;

    assign upper_half    = addr_i[MSB];
    assign upper_quarter = addr_i[MSB] && addr_i[MSB-1];

    // Select the protected region from the code.
    always_comb begin
        unique case (bp_i)
            2'b00:   hit_o = 1'b0;
            2'b01:   hit_o = upper_quarter;
            2'b10:   hit_o = upper_half;
            default: hit_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/sr_status_guard.sv
// Module: status register and array write guard (top).
// Holds the protection code in storage that ignores rst_n, combines flags
// into the status word and grants array writes per address.
// Assumes the front-end issues arr_commit_i only on a valid deselect.
module sr_status_guard
    import sr_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int WR_CYCLES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bp_init_i,
    input  logic                wp_n_i,
    input  logic                wren_i,
    input  logic                wrdi_i,
    input  logic                wrsr_latch_i,
    input  logic [BP_W-1:0]     wrsr_bp_i,
    input  logic                sclk_rise_i,
    input  logic                cs_rise_i,
    input  logic                arr_commit_i,
    input  logic [ADDR_W-1:0]   addr_i,
    output logic                wr_grant_o,
    output logic [STATUS_W-1:0] status_o
);
    logic            wel;
    logic            wip;
    logic            cyc_done;
    cyc_kind_e       cyc_kind;
    logic            prot_hit;
    logic            arm_allow;
    logic            st_start;
    logic            arr_start;
    logic            tmr_start;
    cyc_kind_e       start_kind;
    logic [BP_W-1:0] pend_bp;
    logic [BP_W-1:0] bp_q;

    sr_wel_latch u_wel (
        .clk          (clk),
        .rst_n        (rst_n),
        .wp_n_i       (wp_n_i),
        .wren_i       (wren_i),
        .wrdi_i       (wrdi_i),
        .cycle_done_i (cyc_done),
        .wel_o        (wel)
    );

    sr_block_protect #(.ADDR_W(ADDR_W)) u_prot (
        .bp_i   (bp_q),
        .addr_i (addr_i),
        .hit_o  (prot_hit)
    );

    // Permission shared by array grant and status-write arming.
    assign arm_allow  = wel && wp_n_i && !wip;
    assign wr_grant_o = arm_allow && !prot_hit;

    sr_wrsr_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .allow_i     (arm_allow),
        .latch_i     (wrsr_latch_i),
        .data_i      (wrsr_bp_i),
        .sclk_rise_i (sclk_rise_i),
        .cs_rise_i   (cs_rise_i),
        .start_o     (st_start),
        .pend_bp_o   (pend_bp)
    );

    // An array commit wins if both sources ask in one cycle.
    assign arr_start  = arr_commit_i && wr_grant_o;
    assign tmr_start  = arr_start || (st_start && !wip);
    assign start_kind = arr_start ? CYC_ARRAY : CYC_STATUS;

    sr_write_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .kind_i  (start_kind),
        .busy_o  (wip),
        .done_o  (cyc_done),
        .kind_o  (cyc_kind)
    );

    // Protection code: cleared only by the initial-state strobe, loaded at
    // the end of a status-write cycle; rst_n deliberately not used.
    always_ff @(posedge clk) begin
        if (bp_init_i) begin
            bp_q <= '0;
        end else if (cyc_done && (cyc_kind == CYC_STATUS)) begin
            bp_q <= pend_bp;
        end
    end

    assign status_o = {STATUS_FILL, bp_q, wel, wip};

    // R9: the code read back holds still for the whole running cycle.
    p_bp_hold_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wip && !$past(bp_init_i)) |-> $stable(bp_q))
        else $error("p_bp_hold_busy_r9");

    // R4: full-array code never grants any address.
    p_full_protect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_q == 2'b11) |-> !wr_grant_o)
        else $error("p_full_protect_r4");

    // R6: a granted commit shows busy on the next cycle.
    p_commit_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_commit_i && wr_grant_o) |=> wip)
        else $error("p_commit_busy_r6");
endmodule

// File: tb/tb_sr_status_guard.sv
// Scoreboard bench: driver tasks push expected items stamped with the cycle
// they are due; a monitor pops and compares them at the falling edge.
module tb_sr_status_guard;
    localparam int W = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bp_init_i = 1'b0;
    logic       wp_n_i = 1'b1;
    logic       wren_i = 1'b0;
    logic       wrdi_i = 1'b0;
    logic       wrsr_latch_i = 1'b0;
    logic [1:0] wrsr_bp_i = 2'b00;
    logic       sclk_rise_i = 1'b0;
    logic       cs_rise_i = 1'b0;
    logic       arr_commit_i = 1'b0;
    logic [7:0] addr_i = 8'h00;
    logic       wr_grant_o;
    logic [7:0] status_o;

    sr_status_guard #(.ADDR_W(8), .WR_CYCLES(W)) dut (
        .clk(clk), .rst_n(rst_n), .bp_init_i(bp_init_i), .wp_n_i(wp_n_i),
        .wren_i(wren_i), .wrdi_i(wrdi_i), .wrsr_latch_i(wrsr_latch_i),
        .wrsr_bp_i(wrsr_bp_i), .sclk_rise_i(sclk_rise_i), .cs_rise_i(cs_rise_i),
        .arr_commit_i(arr_commit_i), .addr_i(addr_i),
        .wr_grant_o(wr_grant_o), .status_o(status_o)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        string      req;
        bit         chk_st;
        logic [7:0] st;
        bit         chk_g;
        bit         g;
        int         due;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int checks = 0;
    int fails = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every item due in this cycle.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            it = q.pop_front();
            if (it.due < cyc) begin
                checks++; fails++;
                $display("FAIL %s: item missed due=%0d now=%0d", it.req, it.due, cyc);
            end else begin
                if (it.chk_st) begin
                    checks++;
                    if (status_o !== it.st) begin
                        fails++;
                        $display("FAIL %s: status actual=%h expected=%h", it.req, status_o, it.st);
                    end
                end
                if (it.chk_g) begin
                    checks++;
                    if (wr_grant_o !== it.g) begin
                        fails++;
                        $display("FAIL %s: grant addr=%h actual=%b expected=%b",
                                 it.req, addr_i, wr_grant_o, it.g);
                    end
                end
            end
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic exp_st(string r, logic [7:0] s);
        item_t it;
        it.req = r; it.chk_st = 1'b1; it.st = s; it.chk_g = 1'b0; it.g = 1'b0; it.due = cyc;
        q.push_back(it);
    endtask

    task automatic exp_gr(string r, logic [7:0] a, bit g);
        item_t it;
        addr_i = a;
        it.req = r; it.chk_st = 1'b0; it.st = 8'h00; it.chk_g = 1'b1; it.g = g; it.due = cyc;
        q.push_back(it);
        tick();
    endtask

    task automatic do_wren(); wren_i = 1'b1; tick(); wren_i = 1'b0; endtask
    task automatic do_wrdi(); wrdi_i = 1'b1; tick(); wrdi_i = 1'b0; endtask
    task automatic do_cs();   cs_rise_i = 1'b1; tick(); cs_rise_i = 1'b0; endtask
    task automatic do_sclk(); sclk_rise_i = 1'b1; tick(); sclk_rise_i = 1'b0; endtask
    task automatic do_latch(logic [1:0] v);
        wrsr_bp_i = v; wrsr_latch_i = 1'b1; tick(); wrsr_latch_i = 1'b0;
    endtask
    task automatic do_commit(logic [7:0] a);
        addr_i = a; arr_commit_i = 1'b1; tick(); arr_commit_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        bp_init_i = 1'b1;
        tick(3);
        rst_n = 1'b1; bp_init_i = 1'b0;
        exp_st("R1 R10 initial state", 8'hF0);
        exp_gr("R5 no grant without wel", 8'h10, 1'b0);

        do_wren();           exp_st("R2 wren sets wel", 8'hF2);
        exp_gr("R5 grant low addr", 8'h10, 1'b1);
        exp_gr("R4 code 00 grants top", 8'hFF, 1'b1);
        do_wrdi();           exp_st("R2 wrdi clears wel", 8'hF0);

        do_wren();           exp_st("R2 wren again", 8'hF2);
        wp_n_i = 1'b0; tick(); exp_st("R3 wp low clears wel", 8'hF0);
        do_wren();           exp_st("R3 wren ignored under wp", 8'hF0);
        wp_n_i = 1'b1;

        // Array programming cycle.
        do_wren();           exp_st("R2 wren", 8'hF2);
        do_commit(8'h20);    exp_st("R6 busy after commit", 8'hF3);
        exp_gr("R5 no grant while busy", 8'h20, 1'b0);
        tick(W - 2);         exp_st("R6 busy in last cycle", 8'hF3);
        tick();              exp_st("R7 wel cleared at end", 8'hF0);
        do_commit(8'h30);    exp_st("R6 ungranted commit ignored", 8'hF0);

        // Status write to code 01.
        do_wren();           exp_st("R2 wren", 8'hF2);
        do_latch(2'b01);     exp_st("R8 latch alone no cycle", 8'hF2);
        do_cs();             exp_st("R9 old code while pending", 8'hF3);
        tick(W - 1);         exp_st("R9 still old code", 8'hF3);
        tick();              exp_st("R9 R7 new code at end", 8'hF4);

        do_wren();           exp_st("R2 wren", 8'hF6);
        exp_gr("R4 code 01 below range", 8'hBF, 1'b1);
        exp_gr("R4 code 01 range start", 8'hC0, 1'b0);
        exp_gr("R4 code 01 range end", 8'hFF, 1'b0);

        // Extra serial clock drops the status write.
        do_latch(2'b10); do_sclk(); do_cs();
        exp_st("R8 extra clock drops write", 8'hF6);
        tick(W);             exp_st("R8 code unchanged", 8'hF6);

        // Latch under write-protect is not armed.
        wp_n_i = 1'b0;
        do_latch(2'b10);     exp_st("R3 wp clears wel at latch", 8'hF4);
        wp_n_i = 1'b1;
        do_cs();             exp_st("R3 R8 unarmed deselect", 8'hF4);

        // Running cycle survives write-protect.
        do_wren();           exp_st("R2 wren", 8'hF6);
        do_latch(2'b10); do_cs();
        exp_st("R8 cycle started", 8'hF7);
        wp_n_i = 1'b0; tick();
        exp_st("R11 wel cleared busy kept", 8'hF5);
        tick(W - 1);         exp_st("R11 cycle completes", 8'hF8);
        wp_n_i = 1'b1;

        do_wren();           exp_st("R2 wren", 8'hFA);
        exp_gr("R4 code 10 below half", 8'h7F, 1'b1);
        exp_gr("R4 code 10 half start", 8'h80, 1'b0);

        // Reset keeps the code.
        rst_n = 1'b0; tick(2); rst_n = 1'b1;
        exp_st("R10 code survives reset", 8'hF8);

        // Code 11 protects everything.
        do_wren(); do_latch(2'b11); do_cs();
        tick(W);             exp_st("R9 code 11 committed", 8'hFC);
        do_wren();           exp_st("R2 wren", 8'hFE);
        exp_gr("R4 code 11 low addr", 8'h00, 1'b0);
        exp_gr("R4 code 11 mid addr", 8'h55, 1'b0);

        // Initial-state strobe clears only the code.
        bp_init_i = 1'b1; tick(); bp_init_i = 1'b0;
        exp_st("R10 init clears code only", 8'hF2);
        exp_gr("R4 R10 grant after init", 8'hFF, 1'b1);

        tick(2);
        finish_run();
    end
endmodule